// File: doc/BRIEF.md
# Speculative Global-History Branch Predictor

This block sits in the fetch stage of an in-order pipeline and gives two kinds of prediction. For conditional branches it gives a taken/not-taken guess, read from a table of 2-bit saturating counters. The table is addressed by the XOR of fetch PC bits and a global history of recent branch directions. For returns it gives a target address, read from a small circular return-address stack that calls fill with their fall-through address. Each prediction is combinational within the fetch cycle. The table index used is sent out with the prediction and comes back unchanged when the branch resolves.

The history register and the return stack each exist in two copies. The speculative copy advances at fetch from predicted behaviour. The committed copy advances only from outcomes reported by the single resolution stage. When that stage marks a branch as mispredicted, both speculative structures are overwritten in the same edge with the committed state, including the effect of the branch being resolved. Fetch therefore restarts with correct history and stack contents.

Top module: `spec_branch_predictor`

## Requirements
- R1: `pred_idx` equals `fe_pc[13:2]` XOR the speculative history, and this is the counter entry read for the prediction.
- R2: `pred_taken` is the upper bit of the addressed counter, so values 2 and 3 predict taken.
- R3: A conditional resolve (`rs_kind` = 1) moves the counter at `rs_idx` one step toward the actual outcome, saturating at 0 and 3. Other kinds leave the table alone.
- R4: A fetched conditional branch (`fe_kind` = 1) shifts its predicted direction into bit 0 of the speculative history. Older bits move one place toward the MSB.
- R5: A conditional resolve shifts `rs_taken` into bit 0 of the committed history in the same way. Nothing else changes it.
- R6: When `rs_valid` and `rs_mispredict` are both high, the speculative history becomes the committed history after this resolve's update. Any fetch in that cycle leaves no trace in speculative state.
- R7: A fetched call (`fe_kind` = 2) pushes `fe_pc`+4 onto the speculative stack. A fetched return (`fe_kind` = 3) presents the top entry on `pred_target` and pops it.
- R8: The stack holds 8 entries. A push onto a full stack overwrites the oldest entry, and the 8 newest addresses return in LIFO order.
- R9: A return on an empty stack presents the most recently popped address (0 after reset) and raises `pred_lowconf`. `pred_lowconf` is low for a return on a non-empty stack.
- R10: Resolved calls push `rs_pc`+4 and resolved returns pop on the committed stack. On a mispredict the speculative stack is replaced by the committed stack after this resolve's push or pop.
- R11: After synchronous reset, every counter is 1 (weakly not taken), both histories are zero and both stacks are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fe_valid | input | 1 | Fetch slot holds a branch to predict |
| fe_kind | input | 2 | Fetched branch kind: 0 none, 1 conditional, 2 call, 3 return |
| fe_pc | input | 32 | Fetch PC of the branch |
| pred_taken | output | 1 | Predicted direction for a conditional branch |
| pred_idx | output | 12 | Counter index used, returned later on `rs_idx` |
| pred_target | output | 32 | Predicted return target |
| pred_lowconf | output | 1 | Return predicted from an empty stack |
| rs_valid | input | 1 | A branch resolves this cycle |
| rs_kind | input | 2 | Resolved branch kind, same encoding as `fe_kind` |
| rs_pc | input | 32 | PC of the resolved branch |
| rs_taken | input | 1 | Actual direction of a resolved conditional |
| rs_idx | input | 12 | Counter index captured at prediction |
| rs_mispredict | input | 1 | Resolved branch was mispredicted; restore speculative state |

## Verification
Directed sequences come first. One repeatedly trains a single counter up and down to show saturation at both ends. One pushes ten calls and then pops ten returns, which separates wrap-around overwrite from the empty-pop fallback. One applies a mispredict while wrong-path calls and conditionals sit in speculative state, with a fetch in the same cycle, to show the restore takes the committed value including the resolving branch. Random fetch and resolve traffic then runs over a small PC pool with occasional mispredicts. A reference model in the bench predicts every index, direction, target and confidence flag, so aliasing between history and PC bits and interleaved speculative and committed updates are checked continuously.

// File: rtl/sbp_pkg.sv
package sbp_pkg;

    typedef enum logic [1:0] {
        BK_NONE = 2'd0,
        BK_COND = 2'd1,
        BK_CALL = 2'd2,
        BK_RET  = 2'd3
    } br_kind_e;

    typedef struct packed {
        logic push;
        logic pop;
    } ras_op_t;

    localparam logic [1:0] CTR_WEAK_NT = 2'b01;

    function automatic logic [1:0] ctr_step(input logic [1:0] cur, input logic up);
        logic [1:0] nxt;
        nxt = cur;
        if (up && cur != 2'b11) nxt = cur + 2'b01;
        else if (!up && cur != 2'b00) nxt = cur - 2'b01;
        return nxt;
    endfunction

endpackage

// File: rtl/sbp_pht.sv
module sbp_pht
    import sbp_pkg::*;
#(
    parameter int IDX_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_msb,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);
    localparam int ENTRIES = 1 << IDX_W;

    logic [1:0] tbl [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) tbl[i] <= CTR_WEAK_NT;
        end else if (wr_en) begin
            tbl[wr_idx] <= ctr_step(tbl[wr_idx], wr_taken);
        end
    end

    assign rd_msb = tbl[rd_idx][1];

    AST_CTR_SAT_HIGH: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_taken && tbl[wr_idx] == 2'b11) |=> tbl[$past(wr_idx)] == 2'b11); // R3
    AST_CTR_SAT_LOW: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_taken && tbl[wr_idx] == 2'b00) |=> tbl[$past(wr_idx)] == 2'b00); // R3

endmodule

// File: rtl/sbp_ghr.sv
module sbp_ghr #(
    parameter int HIST_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spec_en,
    input  logic              spec_bit,
    input  logic              comm_en,
    input  logic              comm_bit,
    input  logic              restore,
    output logic [HIST_W-1:0] spec_hist,
    output logic [HIST_W-1:0] comm_hist
);
    logic [HIST_W-1:0] comm_nxt;

    always_comb begin
        comm_nxt = comm_hist;
        if (comm_en) comm_nxt = {comm_hist[HIST_W-2:0], comm_bit};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            spec_hist <= '0;
            comm_hist <= '0;
        end else begin
            comm_hist <= comm_nxt;
            if (restore)      spec_hist <= comm_nxt;
            else if (spec_en) spec_hist <= {spec_hist[HIST_W-2:0], spec_bit};
        end
    end

    AST_SPEC_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (spec_en && !restore) |=> (spec_hist[0] == $past(spec_bit)) &&
                                  (spec_hist[HIST_W-1:1] == $past(spec_hist[HIST_W-2:0]))); // R4
    AST_COMM_HOLD: assert property (@(posedge clk) disable iff (rst)
        !comm_en |=> $stable(comm_hist)); // R5

endmodule

// File: rtl/sbp_ras.sv
module sbp_ras
    import sbp_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int W     = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  ras_op_t                 op,
    input  logic [W-1:0]            push_val,
    input  logic                    load,
    input  logic [DEPTH-1:0][W-1:0] ld_ent,
    input  logic [PTR_W-1:0]        ld_ptr,
    input  logic [CNT_W-1:0]        ld_cnt,
    output logic [DEPTH-1:0][W-1:0] ent,
    output logic [PTR_W-1:0]        ptr,
    output logic [CNT_W-1:0]        cnt
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [DEPTH-1:0][W-1:0] base_ent, nxt_ent;
    logic [PTR_W-1:0]        base_ptr, nxt_ptr, up_ptr, dn_ptr;
    logic [CNT_W-1:0]        base_cnt, nxt_cnt;

    always_comb begin
        base_ent = load ? ld_ent : ent;
        base_ptr = load ? ld_ptr : ptr;
        base_cnt = load ? ld_cnt : cnt;
        up_ptr   = (base_ptr == LAST) ? '0 : base_ptr + 1'b1;
        dn_ptr   = (base_ptr == '0) ? LAST : base_ptr - 1'b1;
        nxt_ent  = base_ent;
        nxt_ptr  = base_ptr;
        nxt_cnt  = base_cnt;
        if (op.push) begin
            nxt_ptr          = up_ptr;
            nxt_ent[up_ptr]  = push_val;
            if (base_cnt != FULL) nxt_cnt = base_cnt + 1'b1;
        end else if (op.pop) begin
            // the pointer stays on the last live slot so an empty pop reuses it
            if (base_cnt > CNT_W'(1)) nxt_ptr = dn_ptr;
            if (base_cnt != '0)       nxt_cnt = base_cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ent <= '0;
            ptr <= '0;
            cnt <= '0;
        end else begin
            ent <= nxt_ent;
            ptr <= nxt_ptr;
            cnt <= nxt_cnt;
        end
    end

    AST_RAS_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= FULL); // R8
    AST_RAS_PUSH_TOP: assert property (@(posedge clk) disable iff (rst)
        op.push |=> ent[ptr] == $past(push_val)); // R7
    AST_RAS_EMPTY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (op.pop && !op.push && !load && cnt == '0) |=> ($stable(ptr) && $stable(ent) && cnt == '0)); // R9

endmodule

// File: rtl/spec_branch_predictor.sv
module spec_branch_predictor
    import sbp_pkg::*;
#(
    parameter int PC_W      = 32,
    parameter int HIST_W    = 12,
    parameter int RAS_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fe_valid,
    input  logic [1:0]        fe_kind,
    input  logic [PC_W-1:0]   fe_pc,
    output logic              pred_taken,
    output logic [HIST_W-1:0] pred_idx,
    output logic [PC_W-1:0]   pred_target,
    output logic              pred_lowconf,
    input  logic              rs_valid,
    input  logic [1:0]        rs_kind,
    input  logic [PC_W-1:0]   rs_pc,
    input  logic              rs_taken,
    input  logic [HIST_W-1:0] rs_idx,
    input  logic              rs_mispredict
);
    localparam int PTR_W = $clog2(RAS_DEPTH);
    localparam int CNT_W = $clog2(RAS_DEPTH + 1);
    localparam logic [PC_W-1:0] STEP = PC_W'(4);

    br_kind_e fk, rk;
    logic     restore, fe_go;
    logic     ctr_msb;
    logic [HIST_W-1:0] spec_hist, comm_hist;

    assign fk      = br_kind_e'(fe_kind);
    assign rk      = br_kind_e'(rs_kind);
    assign restore = rs_valid && rs_mispredict;
    assign fe_go   = fe_valid && !restore;

    assign pred_idx   = fe_pc[HIST_W+1:2] ^ spec_hist;
    assign pred_taken = ctr_msb;

    sbp_pht #(.IDX_W(HIST_W)) u_pht (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (pred_idx),
        .rd_msb   (ctr_msb),
        .wr_en    (rs_valid && rk == BK_COND),
        .wr_idx   (rs_idx),
        .wr_taken (rs_taken)
    );

    sbp_ghr #(.HIST_W(HIST_W)) u_ghr (
        .clk       (clk),
        .rst       (rst),
        .spec_en   (fe_go && fk == BK_COND),
        .spec_bit  (ctr_msb),
        .comm_en   (rs_valid && rk == BK_COND),
        .comm_bit  (rs_taken),
        .restore   (restore),
        .spec_hist (spec_hist),
        .comm_hist (comm_hist)
    );

    ras_op_t                      s_op, c_op;
    logic [PC_W-1:0]              s_val, c_val;
    logic [RAS_DEPTH-1:0][PC_W-1:0] s_ent, c_ent;
    logic [PTR_W-1:0]             s_ptr, c_ptr;
    logic [CNT_W-1:0]             s_cnt, c_cnt;

    always_comb begin
        c_op.push = rs_valid && rk == BK_CALL;
        c_op.pop  = rs_valid && rk == BK_RET;
        c_val     = rs_pc + STEP;
        // on restore the speculative copy replays the resolving op on top of committed state
        if (restore) begin
            s_op  = c_op;
            s_val = c_val;
        end else begin
            s_op.push = fe_go && fk == BK_CALL;
            s_op.pop  = fe_go && fk == BK_RET;
            s_val     = fe_pc + STEP;
        end
    end

    sbp_ras #(.DEPTH(RAS_DEPTH), .W(PC_W)) u_ras_spec (
        .clk      (clk),
        .rst      (rst),
        .op       (s_op),
        .push_val (s_val),
        .load     (restore),
        .ld_ent   (c_ent),
        .ld_ptr   (c_ptr),
        .ld_cnt   (c_cnt),
        .ent      (s_ent),
        .ptr      (s_ptr),
        .cnt      (s_cnt)
    );

    sbp_ras #(.DEPTH(RAS_DEPTH), .W(PC_W)) u_ras_comm (
        .clk      (clk),
        .rst      (rst),
        .op       (c_op),
        .push_val (c_val),
        .load     (1'b0),
        .ld_ent   ('0),
        .ld_ptr   ('0),
        .ld_cnt   ('0),
        .ent      (c_ent),
        .ptr      (c_ptr),
        .cnt      (c_cnt)
    );

    assign pred_target  = s_ent[s_ptr];
    assign pred_lowconf = fe_valid && fk == BK_RET && s_cnt == '0;

    AST_RESTORE_HIST: assert property (@(posedge clk) disable iff (rst)
        restore |=> spec_hist == comm_hist); // R6
    AST_RESTORE_RAS: assert property (@(posedge clk) disable iff (rst)
        restore |=> (s_ptr == c_ptr && s_cnt == c_cnt && s_ent == c_ent)); // R10

endmodule

// File: tb/test_spec_branch_predictor.sv
module test_spec_branch_predictor;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fe_valid = 1'b0;
    logic [1:0]  fe_kind = 2'd0;
    logic [31:0] fe_pc = 32'd0;
    logic        pred_taken;
    logic [11:0] pred_idx;
    logic [31:0] pred_target;
    logic        pred_lowconf;
    logic        rs_valid = 1'b0;
    logic [1:0]  rs_kind = 2'd0;
    logic [31:0] rs_pc = 32'd0;
    logic        rs_taken = 1'b0;
    logic [11:0] rs_idx = 12'd0;
    logic        rs_mispredict = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;

    // 50 MHz: 20 ns period
    always #10 clk = ~clk;

    spec_branch_predictor i_spec_branch_predictor (
        .clk(clk), .rst(rst),
        .fe_valid(fe_valid), .fe_kind(fe_kind), .fe_pc(fe_pc),
        .pred_taken(pred_taken), .pred_idx(pred_idx),
        .pred_target(pred_target), .pred_lowconf(pred_lowconf),
        .rs_valid(rs_valid), .rs_kind(rs_kind), .rs_pc(rs_pc),
        .rs_taken(rs_taken), .rs_idx(rs_idx), .rs_mispredict(rs_mispredict)
    );

    // reference model
    logic [1:0]  mctr [4096];
    logic [11:0] sh, ch;
    logic [31:0] sq[$];
    logic [31:0] cq[$];
    logic [31:0] slast, clast;

    function automatic logic [1:0] sat2(input logic [1:0] c, input logic up);
        if (up)  return (c == 2'b11) ? c : c + 2'b01;
        return (c == 2'b00) ? c : c - 2'b01;
    endfunction

    task automatic spush(input logic [31:0] v);
        if (sq.size() == 8) void'(sq.pop_front());
        sq.push_back(v);
    endtask
    task automatic spop();
        if (sq.size() > 0) slast = sq.pop_back();
    endtask
    task automatic cpush(input logic [31:0] v);
        if (cq.size() == 8) void'(cq.pop_front());
        cq.push_back(v);
    endtask
    task automatic cpop();
        if (cq.size() > 0) clast = cq.pop_back();
    endtask

    task automatic check(input string req, input string ctx, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s [%s] actual=%h expected=%h", req, ctx, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 4096; i++) mctr[i] = 2'b01;
        sh = '0; ch = '0;
        sq.delete(); cq.delete();
        slast = '0; clast = '0;
    endtask

    task automatic step(input logic fv, input logic [1:0] fk, input logic [31:0] fpc,
                        input logic rv, input logic [1:0] rk, input logic [31:0] rpc,
                        input logic rt, input logic [11:0] ri, input logic rm, input string ctx);
        logic [11:0] eidx;
        logic        etk;
        logic [31:0] etgt;
        logic        elc;
        @(negedge clk);
        fe_valid = fv; fe_kind = fk; fe_pc = fpc;
        rs_valid = rv; rs_kind = rk; rs_pc = rpc; rs_taken = rt; rs_idx = ri; rs_mispredict = rm;
        #1;
        eidx = fpc[13:2] ^ sh;
        etk  = mctr[eidx][1];
        etgt = (sq.size() > 0) ? sq[sq.size()-1] : slast;
        elc  = (sq.size() == 0);
        if (fv) begin
            check("R1", ctx, {20'd0, pred_idx}, {20'd0, eidx});
            if (fk == 2'd1) check("R2", ctx, {31'd0, pred_taken}, {31'd0, etk});
            if (fk == 2'd3) begin
                check("R7", ctx, pred_target, etgt);
                check("R9", ctx, {31'd0, pred_lowconf}, {31'd0, elc});
            end
        end
        @(posedge clk);
        if (rv) begin
            case (rk)
                2'd1: begin mctr[ri] = sat2(mctr[ri], rt); ch = {ch[10:0], rt}; end
                2'd2: cpush(rpc + 32'd4);
                2'd3: cpop();
                default: ;
            endcase
        end
        if (rv && rm) begin
            sh = ch; sq = cq; slast = clast;
        end else if (fv) begin
            case (fk)
                2'd1: sh = {sh[10:0], etk};
                2'd2: spush(fpc + 32'd4);
                2'd3: spop();
                default: ;
            endcase
        end
    endtask

    task automatic fetch(input logic [1:0] fk, input logic [31:0] fpc, input string ctx);
        step(1'b1, fk, fpc, 1'b0, 2'd0, 32'd0, 1'b0, 12'd0, 1'b0, ctx);
    endtask
    task automatic resolve(input logic [1:0] rk, input logic [31:0] rpc, input logic rt,
                           input logic [11:0] ri, input logic rm, input string ctx);
        step(1'b0, 2'd0, 32'd0, 1'b1, rk, rpc, rt, ri, rm, ctx);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL R11 [watchdog] actual=hung expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R11: reset state seen at the ports
        fetch(2'd3, 32'h0000_0100, "R11 reset empty stack");
        fetch(2'd1, 32'h0000_2004, "R11 reset weak not-taken");

        // R3: saturation up and down on one counter (R2 taken bit)
        for (int i = 0; i < 4; i++) resolve(2'd1, 32'h154, 1'b1, 12'h055, 1'b0, "R3 train up");
        fetch(2'd1, 32'h0000_0154 ^ {18'd0, sh, 2'b00}, "R3 saturated taken");
        resolve(2'd1, 32'h154, 1'b0, 12'h055, 1'b0, "R3 one step down");
        fetch(2'd1, 32'h0000_0154 ^ {18'd0, sh, 2'b00}, "R3 still taken");
        for (int i = 0; i < 4; i++) resolve(2'd1, 32'h154, 1'b0, 12'h055, 1'b0, "R3 train down");
        fetch(2'd1, 32'h0000_0154 ^ {18'd0, sh, 2'b00}, "R3 saturated not-taken");

        // R4: speculative history shifts with predictions
        for (int i = 0; i < 6; i++) resolve(2'd1, 32'h300, 1'b1, 12'h0C0 ^ sh, 1'b0, "R4 train");
        fetch(2'd1, 32'h0000_0300, "R4 taken shifts in");
        fetch(2'd1, 32'h0000_0300, "R4 new index after shift");

        // R8: overflow then drain past empty (R9)
        for (int i = 0; i < 10; i++) fetch(2'd2, 32'h3000 + 32'(i * 16), "R8 push");
        for (int i = 0; i < 10; i++) fetch(2'd3, 32'h5000, "R8 pop after wrap");

        // R5, R6, R10: committed path, wrong-path fetches, restore
        resolve(2'd2, 32'h7000, 1'b0, 12'd0, 1'b0, "R10 committed call");
        resolve(2'd2, 32'h7100, 1'b0, 12'd0, 1'b0, "R10 committed call");
        resolve(2'd1, 32'h7200, 1'b1, 12'h011, 1'b0, "R5 committed history");
        fetch(2'd2, 32'h9000, "R6 wrong-path call");
        fetch(2'd1, 32'h9100, "R6 wrong-path cond");
        step(1'b1, 2'd2, 32'hA000, 1'b1, 2'd3, 32'h7300, 1'b0, 12'h022, 1'b1, "R10 restore with return");
        fetch(2'd3, 32'h0, "R10 stack after restore");
        fetch(2'd1, 32'h0000_0400, "R6 history after restore");
        step(1'b1, 2'd1, 32'hB000, 1'b1, 2'd1, 32'h7400, 1'b1, 12'h033, 1'b1, "R6 restore with cond outcome");
        fetch(2'd1, 32'h0000_0400, "R5 R6 committed bit visible");
        fetch(2'd3, 32'h0, "R10 second pop");
        fetch(2'd3, 32'h0, "R9 empty after restore");

        // random traffic
        for (int n = 0; n < 3000; n++) begin
            logic        fv, rv, rt, rm;
            logic [1:0]  fk, rk;
            logic [31:0] fpc, rpc;
            logic [11:0] ri;
            fv  = ($urandom % 4) != 0;
            fk  = 2'($urandom % 4);
            fpc = 32'h1000 + 32'(($urandom % 32) * 4);
            rv  = ($urandom % 3) != 0;
            rk  = 2'($urandom % 4);
            rpc = 32'h2000 + 32'(($urandom % 16) * 4);
            rt  = 1'($urandom % 2);
            ri  = (fpc[13:2] ^ sh) ^ 12'($urandom % 4);
            rm  = ($urandom % 10) == 0;
            step(fv, fk, fpc, rv, rk, rpc, rt, ri, rm, "random R1 R3 R7 R10");
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule